// File: doc/BRIEF.md
# Dirty Page Bitmap Marker

This block records which pages of guest memory a device has written while migration logging is on. Each write address the device produces is offered on a valid/ready input. The block turns the address into a 4096-byte chunk number and then into a byte and a bit of a dirty-page bitmap kept in ordinary memory. It sets that bit with a single-byte read-modify-write over a simple request/grant memory port.

The bitmap occupies the byte window from a programmed base address up to, but not including, a programmed end address. A mark that would land at or past the end is thrown away and raises a sticky overflow flag. When the logging control value is anything other than the enable code, addresses are still accepted, but they are dropped without any memory traffic. Only one read-modify-write is in progress at a time. If the target bit is already set, the write-back is skipped.

Top module: `dpm_marker`

## Requirements
- R1: After a synchronous reset, `wr_ready` is 1, `mem_req` is 0 and `ovf_flag` is 0.
- R2: While `log_ctrl` is not 4'h1, an accepted address causes no memory request and leaves `wr_ready` high.
- R3: With logging on, an accepted address A issues a read (`mem_we`=0) at byte address `bmp_base + (A >> 15)`.
- R4: The bit marked is bit A[14:12] of that byte. The write goes to the same byte address with data equal to the read byte OR (1 << A[14:12]).
- R5: If the read byte already has the selected bit set, no write is issued and the block returns to ready.
- R6: If `bmp_base + (A >> 15)` is at or above `bmp_end`, no memory access is made and `ovf_flag` becomes 1. It then stays 1 until reset.
- R7: `wr_ready` is low from the issue of the read until the write (or the skip) completes. While `mem_req` waits for `mem_gnt`, it holds its address, direction and data stable.
- R8: Address bits A[11:0] do not affect which byte or bit is marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| log_ctrl | input | CTRL_W (4) | Logging control value; 4'h1 enables marking |
| bmp_base | input | ADDR_W (32) | First byte address of the bitmap window |
| bmp_end | input | ADDR_W (32) | Byte address just past the bitmap window |
| wr_valid | input | 1 | A device write address is offered |
| wr_ready | output | 1 | Block can take an address |
| wr_addr | input | ADDR_W (32) | Guest address written by the device |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W (32) | Byte address of the access |
| mem_wdata | output | 8 | Write byte |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read byte is valid this cycle |
| mem_rdata | input | 8 | Read byte |
| ovf_flag | output | 1 | Sticky: a mark fell outside the window |

## Verification
The assertions assume that `log_ctrl`, `bmp_base` and `bmp_end` change only while the block is idle. They also assume that the memory returns exactly one `mem_rvalid` pulse for each granted read and never raises it otherwise. The bench changes the configuration only between marks, after it has seen `wr_ready` return high. Its memory model grants at random but produces exactly one read response, one cycle after each read grant. Random addresses are drawn so that byte indices fall just inside and just outside the window.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    localparam int CTRL_W   = 4;
    localparam int BYTE_W   = 8;
    localparam int BITSEL_W = $clog2(BYTE_W);

    localparam logic [CTRL_W-1:0] LOG_ON_CODE = 4'h1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_REQ  = 2'd1,
        ST_RD_WAIT = 2'd2,
        ST_WR_REQ  = 2'd3
    } dpm_state_e;

    typedef struct packed {
        logic              in_window;
        logic [BYTE_W-1:0] mask;
    } mark_sel_t;

    function automatic logic [BYTE_W-1:0] bit_mask(input logic [BITSEL_W-1:0] idx);
        logic [BYTE_W-1:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dpm_addr_calc.sv
module dpm_addr_calc #(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_SHIFT = 12
) (
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [ADDR_W-1:0]      bmp_base,
    input  logic [ADDR_W-1:0]      bmp_end,
    output logic [ADDR_W-1:0]      byte_addr,
    output dpm_pkg::mark_sel_t     sel
);
    import dpm_pkg::*;

    localparam int IDX_SHIFT = CHUNK_SHIFT + BITSEL_W;

    logic [ADDR_W:0]       sum;
    logic [BITSEL_W-1:0]   bit_idx;

    always_comb begin
        sum           = {1'b0, bmp_base} + {1'b0, (wr_addr >> IDX_SHIFT)};
        byte_addr     = sum[ADDR_W-1:0];
        bit_idx       = wr_addr[CHUNK_SHIFT +: BITSEL_W];
        sel.mask      = bit_mask(bit_idx);
        sel.in_window = (sum < {1'b0, bmp_end});
    end

endmodule

// File: rtl/dpm_rmw_seq.sv
module dpm_rmw_seq #(
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [dpm_pkg::CTRL_W-1:0]  log_ctrl,
    input  logic                        wr_valid,
    output logic                        wr_ready,
    input  logic [ADDR_W-1:0]           byte_addr,
    input  dpm_pkg::mark_sel_t          sel,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [dpm_pkg::BYTE_W-1:0]  mem_wdata,
    input  logic                        mem_gnt,
    input  logic                        mem_rvalid,
    input  logic [dpm_pkg::BYTE_W-1:0]  mem_rdata,
    output logic                        ovf_flag
);
    import dpm_pkg::*;

    dpm_state_e          state;
    logic [ADDR_W-1:0]   addr_q;
    logic [BYTE_W-1:0]   mask_q;
    logic [BYTE_W-1:0]   wdata_q;
    logic                accept;
    logic                enabled;
    logic                already_set;

    always_comb begin
        accept      = wr_valid && wr_ready;
        enabled     = (log_ctrl == LOG_ON_CODE);
        already_set = (mem_rdata & mask_q) != '0;
        wr_ready    = (state == ST_IDLE);
        mem_req     = (state == ST_RD_REQ) || (state == ST_WR_REQ);
        mem_we      = (state == ST_WR_REQ);
        mem_addr    = addr_q;
        mem_wdata   = wdata_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            addr_q   <= '0;
            mask_q   <= '0;
            wdata_q  <= '0;
            ovf_flag <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept && enabled) begin
                        if (sel.in_window) begin
                            addr_q <= byte_addr;
                            mask_q <= sel.mask;
                            state  <= ST_RD_REQ;
                        end else begin
                            ovf_flag <= 1'b1;
                        end
                    end
                end
                ST_RD_REQ: begin
                    if (mem_gnt) state <= ST_RD_WAIT;
                end
                ST_RD_WAIT: begin
                    if (mem_rvalid) begin
                        if (already_set) begin
                            state <= ST_IDLE;
                        end else begin
                            wdata_q <= mem_rdata | mask_q;
                            state   <= ST_WR_REQ;
                        end
                    end
                end
                ST_WR_REQ: begin
                    if (mem_gnt) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !wr_ready); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R7

    AST_WDATA_HAS_BIT: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> ((mem_wdata & mask_q) != '0)); // R4

    AST_DISABLED_DROP: assert property (@(posedge clk) disable iff (rst)
        (accept && !enabled) |=> (!mem_req && wr_ready)); // R2

    AST_SKIP_SET_BIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_WAIT && mem_rvalid && already_set) |=> (!mem_req && wr_ready)); // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag); // R6

endmodule

// File: rtl/dpm_marker.sv
module dpm_marker #(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_SHIFT = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [dpm_pkg::CTRL_W-1:0]  log_ctrl,
    input  logic [ADDR_W-1:0]           bmp_base,
    input  logic [ADDR_W-1:0]           bmp_end,
    input  logic                        wr_valid,
    output logic                        wr_ready,
    input  logic [ADDR_W-1:0]           wr_addr,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [dpm_pkg::BYTE_W-1:0]  mem_wdata,
    input  logic                        mem_gnt,
    input  logic                        mem_rvalid,
    input  logic [dpm_pkg::BYTE_W-1:0]  mem_rdata,
    output logic                        ovf_flag
);
    import dpm_pkg::*;

    logic [ADDR_W-1:0] calc_byte_addr;
    mark_sel_t         calc_sel;

    dpm_addr_calc #(
        .ADDR_W      (ADDR_W),
        .CHUNK_SHIFT (CHUNK_SHIFT)
    ) u_calc (
        .wr_addr   (wr_addr),
        .bmp_base  (bmp_base),
        .bmp_end   (bmp_end),
        .byte_addr (calc_byte_addr),
        .sel       (calc_sel)
    );

    dpm_rmw_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .log_ctrl   (log_ctrl),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .byte_addr  (calc_byte_addr),
        .sel        (calc_sel),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .ovf_flag   (ovf_flag)
    );

    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr >= bmp_base && mem_addr < bmp_end)); // R6

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (wr_ready && !mem_req)); // R1

endmodule

// File: tb/dpm_marker_test.sv
`timescale 1ns/1ps
module dpm_marker_test;

    localparam int AW = 32;
    localparam logic [AW-1:0] BASE = 32'h10;
    localparam logic [AW-1:0] ENDA = 32'h1C;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    log_ctrl = 4'h0;
    logic [AW-1:0] bmp_base = BASE;
    logic [AW-1:0] bmp_end  = ENDA;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [AW-1:0] wr_addr = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_gnt = 1'b0;
    logic          mem_rvalid = 1'b0;
    logic [7:0]    mem_rdata = 8'h0;
    logic          ovf_flag;

    dpm_marker uut (
        .clk(clk), .rst(rst), .log_ctrl(log_ctrl), .bmp_base(bmp_base), .bmp_end(bmp_end),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .ovf_flag(ovf_flag)
    );

    always #2.5 clk = ~clk;

    logic [7:0] mem     [0:255];
    logic [7:0] exp_mem [0:255];
    int   tests = 0, fails = 0;
    int   rd_cnt = 0, wr_cnt = 0, busy_ready_viol = 0, wr_addr_viol = 0;
    logic [7:0] last_rd = 8'h0;
    logic exp_ovf = 1'b0;
    bit   done = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // memory responder: random grant, one read response one cycle after grant
    initial begin : responder
        logic req_q, we_q, rv_next;
        logic [7:0] a_q, d_q;
        req_q = 0; we_q = 0; a_q = 0; d_q = 0; rv_next = 0;
        forever begin
            @(negedge clk);
            if (req_q && mem_gnt && !rst) begin
                if (we_q) begin
                    wr_cnt++;
                    if (a_q != last_rd) wr_addr_viol++;
                    mem[a_q] = d_q;
                end else begin
                    rd_cnt++;
                    last_rd = a_q;
                    rv_next = 1;
                end
            end
            mem_rvalid = rv_next;
            if (rv_next) mem_rdata = mem[last_rd];
            rv_next = 0;
            if (!rst && mem_req && wr_ready) busy_ready_viol++;
            req_q = mem_req; we_q = mem_we; a_q = mem_addr[7:0]; d_q = mem_wdata;
            mem_gnt = mem_req && ($urandom_range(0, 3) != 0);
        end
    end

    task automatic do_mark(input logic [31:0] a, input logic [3:0] ctl, input string tag);
        logic [31:0] baddr;
        logic [2:0]  bi;
        logic        en, inwin, need_wr;
        int          rd0, wr0, guard;
        @(negedge clk);
        log_ctrl = ctl;
        baddr = BASE + (a >> 15);
        bi    = a[14:12];
        en    = (ctl == 4'h1);
        inwin = baddr < ENDA;
        need_wr = en && inwin && !exp_mem[baddr[7:0]][bi];
        if (need_wr) exp_mem[baddr[7:0]][bi] = 1'b1;
        if (en && !inwin) exp_ovf = 1'b1;
        rd0 = rd_cnt; wr0 = wr_cnt;
        wr_addr = a; wr_valid = 1'b1;
        guard = 0;
        while (!wr_ready && guard < 50) begin @(negedge clk); guard++; end
        @(negedge clk);
        wr_valid = 1'b0;
        guard = 0;
        while (!wr_ready && guard < 200) begin @(negedge clk); guard++; end
        @(negedge clk);
        @(negedge clk);
        chk({tag, " reads"},  rd_cnt - rd0, (en && inwin) ? 1 : 0);
        chk({tag, " writes"}, wr_cnt - wr0, need_wr ? 1 : 0);
        if (en && inwin) begin
            chk({tag, " R3 read byte address"}, {24'h0, last_rd}, baddr);
            chk({tag, " R4 bitmap byte"}, {24'h0, mem[baddr[7:0]]}, {24'h0, exp_mem[baddr[7:0]]});
        end
        chk({tag, " R6 overflow flag"}, {31'h0, ovf_flag}, {31'h0, exp_ovf});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin : main
        logic [31:0] a;
        logic [3:0]  c;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin
            mem[i] = (i >= 32'h10 && i < 32'h1C && (i % 3 == 0)) ? 8'($urandom) : 8'h00;
            exp_mem[i] = mem[i];
        end
        mem[8'h10] = 8'h00; exp_mem[8'h10] = 8'h00;
        mem[8'h11] = 8'h00; exp_mem[8'h11] = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 ready in reset", {31'h0, wr_ready}, 1);
        chk("R1 req in reset",   {31'h0, mem_req}, 0);
        chk("R1 ovf in reset",   {31'h0, ovf_flag}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", {31'h0, wr_ready}, 1);

        // directed corner cases
        do_mark(32'h0000_3000, 4'h1, "R3 R4 first mark bit3");
        do_mark(32'h0000_3000, 4'h1, "R5 same bit again");
        do_mark(32'h0000_3FFF, 4'h1, "R8 low bits differ");
        do_mark(32'h0000_7ABC, 4'h1, "R4 top bit of byte");
        do_mark(32'h0000_8000, 4'h1, "R3 next byte bit0");
        do_mark(32'h0000_9000, 4'h0, "R2 disabled code 0");
        chk("R2 no mark while off", {24'h0, mem[8'h11]}, 32'h01);
        do_mark(32'h0000_A000, 4'h3, "R2 other code");
        do_mark(32'h0005_8000, 4'h1, "R3 last byte in window");
        do_mark(32'h0006_0000, 4'h1, "R6 first byte past end");
        do_mark(32'h0000_9000, 4'h1, "R6 sticky after good mark");

        // random marks
        for (int i = 0; i < 300; i++) begin
            a = ($urandom_range(0, 14) << 15) | ($urandom & 32'h7FFF);
            c = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 15)) : 4'h1;
            do_mark(a, c, "random");
        end

        for (int i = 8'h10; i < 8'h1C; i++)
            chk("R4 final bitmap", {24'h0, mem[i]}, {24'h0, exp_mem[i]});
        chk("R7 ready low while busy", busy_ready_viol, 0);
        chk("R4 write to read address", wr_addr_viol, 0);
        finish_run();
    end

endmodule